// File: doc/BRIEF.md
# I2S Halfword-Packing Duplex Bridge

The bridge is a full-duplex I2S bus master placed between a 24-bit audio converter pair (one ADC, one DAC) and a host data port that is only 16 bits wide. It derives a bit clock and a word-select clock from the system clock. The ADC and the DAC both use these two clocks. The bridge shifts one serial stream in and another out at the same time. Every 24-bit channel sample travels in a 32-bit slot on the line, and crosses the host port as two halfwords: the top 16 sample bits first, then the lowest 8 sample bits in the upper byte of a second halfword.

Receive and transmit each use a ping-pong buffer made of two halves. The serial side fills the receive half and drains the transmit half of the same index. When it finishes a half, it pulses a strobe, so the host can service that half while the serial side works on the other one. A sticky flag records when a filled receive half is overwritten before the host has consumed it.

Top module: `i2s_hw_bridge`

## Requirements
- R1: The bit clock `sclk_o` has a period of 2*CLK_DIV system clocks with equal high and low times.
- R2: A frame is 64 bit clocks and holds two 32-bit slots, left first. `ws_o` is low for the left slot and high for the right slot. It changes on the falling bit-clock edge one bit before the first bit of the slot, so the first rise of `ws_o` after reset comes on the 32nd falling edge.
- R3: Both serial directions carry the most significant bit first. `sd_o` changes on falling edges of `sclk_o`, and `sd_i` is sampled on rising edges.
- R4: Receive unpacking. Word index w = 2*frame_in_buffer + channel (channel 0 is left). Halfword address 2*w returns slot bits 31..16. Address 2*w+1 returns slot bits 15..8 in its bits 15..8 and zero in bits 7..0. The eight received pad bits (slot bits 7..0) have no effect.
- R5: Transmit packing. The host writes halfword 2*w to set slot bits 31..16 and halfword 2*w+1 bits 15..8 to set slot bits 15..8. Bits 7..0 of that second halfword are ignored, and slot bits 7..0 are always sent as zero.
- R6: The buffer has two halves of FRAMES_PER_HALF frames each. Half 0 covers halfword addresses 0 to 4*FRAMES_PER_HALF-1 and half 1 the rest. The serial side uses half 0 and then half 1, cyclically, for both directions.
- R7: `evt_half` pulses for one cycle when the last slot of half 0 completes, and `evt_full` when the last slot of half 1 completes. The two never pulse together.
- R8: A receive half counts as consumed when the host reads its highest halfword address. `overrun` goes high when a half completes while its previous contents are still unconsumed. It stays high until `ovr_clr`, and a new overrun in the same cycle wins over the clear.
- R9: During and right after reset, `sclk_o` is high and `ws_o`, `sd_o`, both strobes, `overrun` and `rd_data` are low. The first slot sent after reset is all zeros.
- R10: `rd_data` shows the addressed halfword one cycle after `rd_en` and holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_o | output | 1 | Bit clock to ADC and DAC |
| ws_o | output | 1 | Word select, low for left slot |
| sd_o | output | 1 | Serial data to DAC |
| sd_i | input | 1 | Serial data from ADC |
| rd_en | input | 1 | Receive buffer read strobe |
| rd_addr | input | AW | Receive halfword address |
| rd_data | output | 16 | Receive halfword, registered |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_addr | input | AW | Transmit halfword address |
| wr_data | input | 16 | Transmit halfword |
| ovr_clr | input | 1 | Clears the overrun flag |
| evt_half | output | 1 | Half 0 finished pulse |
| evt_full | output | 1 | Half 1 finished pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A slot counter that drifts from the bit position would put received words at the wrong addresses. The halfword reads at the next strobe would expose it, within one half of the buffer. A wrong word-select phase, or a shift register loaded on the wrong edge, moves every bit. That shows up at the first halfword compared after the frame, and in the serial slots captured from `sd_o` in the same frame. Missed pending bookkeeping shows up as a wrong `overrun` level at the strobe of the third half after the host stops reading.

// File: rtl/i2s_hw_pkg.sv
package i2s_hw_pkg;
  localparam int SLOT_W  = 32;
  localparam int SAMP_W  = 24;
  localparam int HW_W    = 16;
  localparam int PAD_W   = SLOT_W - SAMP_W;
  localparam int LO_W    = SAMP_W - HW_W;
  localparam int BIT_W   = $clog2(SLOT_W);
  localparam int POS_W   = BIT_W + 1;
endpackage

// File: rtl/i2s_hw_clkgen.sv
module i2s_hw_clkgen
  import i2s_hw_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             sclk_o,
  output logic             ws_o,
  output logic             fall_tk,
  output logic             rise_tk,
  output logic [BIT_W-1:0] bit_q,
  output logic [BIT_W-1:0] bit_nx,
  output logic             chan_q
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0]    div_q;
  logic             sclk_q, ws_q, tick;
  logic [POS_W-1:0] pos_q, pos_nx, pos_ahead;

  assign tick      = (div_q == DW'(CLK_DIV - 1));
  assign pos_nx    = pos_q + POS_W'(1);
  assign pos_ahead = pos_q + POS_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
      pos_q  <= '1;
      ws_q   <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) begin
        sclk_q <= ~sclk_q;
        if (sclk_q) begin
          pos_q <= pos_nx;
          ws_q  <= pos_ahead[POS_W-1];
        end
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign ws_o    = ws_q;
  assign fall_tk = tick & sclk_q;
  assign rise_tk = tick & ~sclk_q;
  assign bit_q   = pos_q[BIT_W-1:0];
  assign bit_nx  = pos_nx[BIT_W-1:0];
  assign chan_q  = pos_q[POS_W-1];
endmodule

// File: rtl/i2s_hw_rx.sv
module i2s_hw_rx
  import i2s_hw_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IW     = 2,
  parameter int AW     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_tk,
  input  logic            commit,
  input  logic [IW-1:0]   wr_idx,
  input  logic            sd_i,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [HW_W-1:0] rd_data
);
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] nxt;
  logic [HW_W-1:0]   mem_hi [NWORDS];
  logic [LO_W-1:0]   mem_lo [NWORDS];
  logic [HW_W-1:0]   rd_q;
  logic [IW-1:0]     rd_w;

  assign nxt  = {sh_q, sd_i};
  assign rd_w = rd_addr[AW-1:1];

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else if (rise_tk) sh_q <= nxt[SLOT_W-2:0];
  end

  // sample storage: one write port (serial), one read port (host)
  always_ff @(posedge clk) begin
    if (commit) begin
      mem_hi[wr_idx] <= nxt[SLOT_W-1:SLOT_W-HW_W];
      mem_lo[wr_idx] <= nxt[SLOT_W-HW_W-1:PAD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) rd_q <= rd_addr[0] ? {mem_lo[rd_w], {PAD_W{1'b0}}} : mem_hi[rd_w];
  end

  assign rd_data = rd_q;

  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    commit |-> rise_tk); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: rtl/i2s_hw_tx.sv
module i2s_hw_tx
  import i2s_hw_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IW     = 2,
  parameter int AW     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_tk,
  input  logic [BIT_W-1:0] bit_nx,
  input  logic [IW-1:0]    fetch_idx,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [HW_W-1:0]  wr_data,
  output logic             sd_o
);
  localparam logic [BIT_W-1:0] FETCH_AT = BIT_W'(SLOT_W / 2);
  localparam logic [BIT_W-1:0] PAD_AT   = BIT_W'(SAMP_W);

  logic [HW_W-1:0]   mem_hi [NWORDS];
  logic [LO_W-1:0]   mem_lo [NWORDS];
  logic [SAMP_W-1:0] pre_q;
  logic [SLOT_W-1:0] sh_q;
  logic [IW-1:0]     wr_w;
  logic              unused_pad;

  assign wr_w       = wr_addr[AW-1:1];
  assign unused_pad = ^wr_data[PAD_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_addr[0]) mem_lo[wr_w] <= wr_data[HW_W-1:PAD_W];
      else            mem_hi[wr_w] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      sh_q  <= '0;
    end else if (fall_tk) begin
      if (bit_nx == FETCH_AT) pre_q <= {mem_hi[fetch_idx], mem_lo[fetch_idx]};
      if (bit_nx == '0) sh_q <= {pre_q, {PAD_W{1'b0}}};
      else              sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
    end
  end

  assign sd_o = sh_q[SLOT_W-1];

  AST_PAD_LOW: assert property (@(posedge clk) disable iff (rst)
    (fall_tk && bit_nx >= PAD_AT) |=> !sd_o); // R5
  AST_SD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fall_tk |=> $stable(sd_o)); // R3
endmodule

// File: rtl/i2s_hw_bridge.sv
module i2s_hw_bridge
  import i2s_hw_pkg::*;
#(
  parameter int CLK_DIV         = 2,
  parameter int FRAMES_PER_HALF = 1,
  localparam int WPH            = 2 * FRAMES_PER_HALF,
  localparam int NWORDS         = 2 * WPH,
  localparam int IW             = $clog2(NWORDS),
  localparam int AW             = IW + 1,
  localparam int HPH            = 2 * WPH
) (
  input  logic            clk,
  input  logic            rst,
  output logic            sclk_o,
  output logic            ws_o,
  output logic            sd_o,
  input  logic            sd_i,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [HW_W-1:0] rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [HW_W-1:0] wr_data,
  input  logic            ovr_clr,
  output logic            evt_half,
  output logic            evt_full,
  output logic            overrun
);
  logic             fall_tk, rise_tk, chan_q;
  logic [BIT_W-1:0] bit_q, bit_nx;
  logic [IW-1:0]    cur_q, nxt_idx;
  logic             commit, done0, done1, clear0, clear1;
  logic [1:0]       pend_q;
  logic             evt_h_q, evt_f_q, ovr_q;

  i2s_hw_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst(rst), .sclk_o(sclk_o), .ws_o(ws_o),
    .fall_tk(fall_tk), .rise_tk(rise_tk),
    .bit_q(bit_q), .bit_nx(bit_nx), .chan_q(chan_q)
  );

  // slot index within the ping-pong buffer, advanced at each slot start
  assign nxt_idx = (cur_q == IW'(NWORDS - 1)) ? '0 : cur_q + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) cur_q <= IW'(NWORDS - 1);
    else if (fall_tk && bit_nx == '0) cur_q <= nxt_idx;
  end

  assign commit = rise_tk && (bit_q == BIT_W'(SLOT_W - 1));
  assign done0  = commit && (cur_q == IW'(WPH - 1));
  assign done1  = commit && (cur_q == IW'(NWORDS - 1));
  assign clear0 = rd_en && (rd_addr == AW'(HPH - 1));
  assign clear1 = rd_en && (rd_addr == AW'(2 * HPH - 1));

  i2s_hw_rx #(.NWORDS(NWORDS), .IW(IW), .AW(AW)) u_rx (
    .clk(clk), .rst(rst), .rise_tk(rise_tk), .commit(commit),
    .wr_idx(cur_q), .sd_i(sd_i),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  i2s_hw_tx #(.NWORDS(NWORDS), .IW(IW), .AW(AW)) u_tx (
    .clk(clk), .rst(rst), .fall_tk(fall_tk), .bit_nx(bit_nx),
    .fetch_idx(nxt_idx), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sd_o(sd_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_h_q <= 1'b0;
      evt_f_q <= 1'b0;
      pend_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      evt_h_q <= done0;
      evt_f_q <= done1;
      if (done0) pend_q[0] <= 1'b1;
      else if (clear0) pend_q[0] <= 1'b0;
      if (done1) pend_q[1] <= 1'b1;
      else if (clear1) pend_q[1] <= 1'b0;
      if ((done0 && pend_q[0]) || (done1 && pend_q[1])) ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  assign evt_half = evt_h_q;
  assign evt_full = evt_f_q;
  assign overrun  = ovr_q;

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(evt_half && evt_full)); // R7
  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (rst)
    evt_half |=> !evt_half); // R7
  AST_WS_LEADS: assert property (@(posedge clk) disable iff (rst)
    commit |-> (ws_o != cur_q[0])); // R2
  AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    cur_q[0] == chan_q); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun); // R8
endmodule

// File: tb/test_i2s_hw_bridge.sv
`timescale 1ns/1ps
module test_i2s_hw_bridge;
  localparam int CLK_DIV = 2;
  localparam int AW = 3;

  typedef struct packed {
    logic [31:0] adc_l, adc_r;
    logic [15:0] tlh, tll, trh, trl;
    logic [15:0] e0, e1, e2, e3;
    logic [31:0] etl, etr;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{32'hA1B2C35A, 32'h0F1E2DFF, 16'h8EAA, 16'h33C7, 16'h1234, 16'h56FF,
      16'hA1B2, 16'hC300, 16'h0F1E, 16'h2D00, 32'h8EAA3300, 32'h12345600},
    '{32'h80000101, 32'h7FFFFF80, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h01FE,
      16'h8000, 16'h0100, 16'h7FFF, 16'hFF00, 32'hFFFFFF00, 32'h00000100},
    '{32'hFFFFFFFF, 32'h00000000, 16'h5555, 16'hAA11, 16'hC001, 16'h8000,
      16'hFFFF, 16'hFF00, 16'h0000, 16'h0000, 32'h5555AA00, 32'hC0018000},
    '{32'h13579B00, 32'h2468ACE1, 16'h0001, 16'h0000, 16'h8000, 16'h0000,
      16'h1357, 16'h9B00, 16'h2468, 16'hAC00, 32'h00010000, 32'h80000000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sclk_o, ws_o, sd_o, sd_i;
  logic rd_en = 1'b0, wr_en = 1'b0, ovr_clr = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [15:0] rd_data, wr_data = '0;
  logic evt_half, evt_full, overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  i2s_hw_bridge #(.CLK_DIV(CLK_DIV), .FRAMES_PER_HALF(1)) i_i2s_hw_bridge (
    .clk(clk), .rst(rst), .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o), .sd_i(sd_i),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovr_clr(ovr_clr), .evt_half(evt_half), .evt_full(evt_full), .overrun(overrun)
  );

  initial forever #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // converter model: ADC drives, DAC capture, aligned only by ws_o
  int idx = 0, ch = 0, pch = 0, afr = -1, nfall = 0, ws_rise_at = -1;
  bit pend = 1;
  logic ws_prev = 1'b0;
  logic [31:0] txcap = '0, word;
  logic [31:0] tx_got [8][2];

  initial begin
    sd_i = 1'b0;
    forever begin
      @(negedge sclk_o); #1;
      nfall++;
      if (pend) begin
        idx = 31; ch = pch; pend = 0;
        if (ch == 0) afr++;
      end else if (idx > 0) idx--;
      if (ws_o != ws_prev) begin
        pend = 1; pch = int'(ws_o);
        if (ws_o && ws_rise_at < 0) ws_rise_at = nfall;
      end
      ws_prev = ws_o;
      word = (afr >= 0 && afr < 4) ? (ch != 0 ? VEC[afr].adc_r : VEC[afr].adc_l) : 32'h0;
      sd_i = word[idx];
    end
  end

  initial forever begin
    @(posedge sclk_o); #1;
    txcap = {txcap[30:0], sd_o};
    if (afr >= 0 && afr < 8 && idx == 0) tx_got[afr][ch] = txcap;
  end

  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_half(input int h, input int v);
    wr(h*4 + 0, VEC[v].tlh); wr(h*4 + 1, VEC[v].tll);
    wr(h*4 + 2, VEC[v].trh); wr(h*4 + 3, VEC[v].trl);
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_evt(input bit full);
    do @(negedge clk); while (!(full ? evt_full : evt_half));
    chk("R7 other strobe low", {31'b0, full ? evt_half : evt_full}, 32'h0);
    @(negedge clk);
    chk("R7 single-cycle pulse", {31'b0, full ? evt_full : evt_half}, 32'h0);
  endtask

  initial begin
    logic [15:0] d;
    realtime t0, t1, t2;
    repeat (3) @(negedge clk);
    chk("R9 sclk high in reset", {31'b0, sclk_o}, 32'h1);
    chk("R9 ws low in reset", {31'b0, ws_o}, 32'h0);
    chk("R9 sd low in reset", {31'b0, sd_o}, 32'h0);
    chk("R9 strobes/flag low", {29'b0, evt_half, evt_full, overrun}, 32'h0);
    chk("R9 rd_data zero", {16'b0, rd_data}, 32'h0);
    rst = 1'b0;
    wr_half(0, 0);
    wr_half(1, 1);

    @(posedge sclk_o); t0 = $realtime;
    @(negedge sclk_o); t1 = $realtime;
    @(posedge sclk_o); t2 = $realtime;
    chk("R1 bit clock period ns", 32'(int'(t2 - t0)), 32'(2*CLK_DIV*20));
    chk("R1 bit clock high time ns", 32'(int'(t1 - t0)), 32'(CLK_DIV*20));

    // table walk: each strobe checks the finished receive half, refills transmit
    for (int f = 0; f < 4; f++) begin
      wait_evt(f % 2 == 1);
      rd((f%2)*4 + 0, d); chk("R4 R6 left upper halfword", {16'b0, d}, {16'b0, VEC[f].e0});
      rd((f%2)*4 + 1, d); chk("R4 left low byte, pad ignored", {16'b0, d}, {16'b0, VEC[f].e1});
      rd((f%2)*4 + 2, d); chk("R4 R6 right upper halfword", {16'b0, d}, {16'b0, VEC[f].e2});
      rd((f%2)*4 + 3, d); chk("R4 right low byte, pad ignored", {16'b0, d}, {16'b0, VEC[f].e3});
      if (f < 2) wr_half(f % 2, f + 2);
    end
    repeat (5) @(negedge clk);
    chk("R10 rd_data holds without rd_en", {16'b0, rd_data}, {16'b0, VEC[3].e3});

    chk("R2 first ws rise on falling edge 32", 32'(ws_rise_at), 32'd32);
    chk("R9 first slot sent is zero", tx_got[0][0], 32'h0);
    chk("R5 R3 frame0 right slot", tx_got[0][1], VEC[0].etr);
    for (int f = 1; f < 4; f++) begin
      chk("R5 R6 left slot packing", tx_got[f][0], VEC[f].etl);
      chk("R5 R6 right slot packing", tx_got[f][1], VEC[f].etr);
    end

    // host stops reading: third unread half raises the flag
    wait_evt(0);
    wait_evt(1);
    chk("R8 no overrun while halves fresh", {31'b0, overrun}, 32'h0);
    wait_evt(0);
    chk("R8 overrun on unread half", {31'b0, overrun}, 32'h1);
    wait_evt(1);
    chk("R8 overrun sticky", {31'b0, overrun}, 32'h1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R8 cleared by ovr_clr", {31'b0, overrun}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule